// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Mask and Pending Controller

This block holds the per-vector message table, the pending bits and the capability control word for a small set of message-signalled interrupt vectors. Software sets vector mode and a function-wide mask through a configuration-write port. It programs each vector's message address, data and mask through a 32-bit table port. Hardware raises per-vector event requests. The block turns each event into a message request for an external sender, which accepts it with a valid/ready handshake. An event whose vector is masked is parked in a pending bit. That event is replayed without software action once the vector becomes unmasked.

Clearing the function mask starts a sweep over all vectors in ascending order. The sweep replays one pending, unmasked vector at a time and waits until that message has left before it moves on. A legacy level interrupt passes through the block and is held low whenever vector mode is on.

Top module: `msgvec_ctrl`

## Requirements
- R1: The control word reads enable in bit 15, function mask in bit 14, zero in bits 13:11 and the vector count minus one in bits 10:0. Both flags reset to 0 and are written through bits 7 and 6 of the control byte at CAP_BASE+3.
- R2: The table-location word carries BAR_SEL in bits 2:0 and the table offset in bits 31:3.
- R3: A configuration write changes the flags only when its byte range, from cfg_wr_addr up to but not including cfg_wr_addr+cfg_wr_len, contains CAP_BASE+3. Data byte k belongs to address cfg_wr_addr+k.
- R4: Each vector owns 16 table bytes: address low at 0, address high at 4, data at 8, vector control at 12. Bit 0 of vector control is the vector's mask, its other bits read 0, and the mask resets to 1 while all other fields reset to 0. Address bits 1:0 are ignored, and the vector index is the address divided by 16.
- R5: A vector counts as masked when the function mask or its own mask is 1. An event on a masked vector while enabled sets that vector's pending bit and sends no message.
- R6: An event on an unmasked vector while enabled sends one message carrying the vector number, the 64-bit address {high, low} and the data word. Messages queued together leave lowest vector number first.
- R7: An event while vector mode is disabled is dropped: no pending bit is set and no message is sent.
- R8: After any table write to an entry, if vector mode is enabled and that vector is pending and now unmasked, its pending bit is cleared and its message is sent. A write that leaves the vector masked sends nothing.
- R9: A control-byte write that leaves enable at 1 and the function mask at 0 visits vectors 0 to N-1 in order. It replays each one that is pending and unmasked, and holds at a replayed vector until its message has been accepted.
- R10: A control-byte write that leaves enable at 0 or the function mask at 1 replays nothing, and the pending bits are kept.
- R11: legacy_out is 0 while enable is 1. Otherwise it follows legacy_in one cycle later.
- R12: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and the message fields hold their values.
- R13: During a sweep, an event for an unmasked vector the sweep has already passed is sent directly, without waiting for the sweep to finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Byte address of the first written byte |
| cfg_wr_len | input | 3 | Number of bytes written (1 to 4) |
| cfg_wr_data | input | 32 | Write data, byte k at address cfg_wr_addr+k |
| cfg_ctrl_word | output | 16 | Capability control word |
| cfg_tbl_word | output | 32 | Table offset and BAR select word |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | TBL_AW | Table write byte address |
| tbl_wr_data | input | 32 | Table write data |
| tbl_rd_addr | input | TBL_AW | Table read byte address |
| tbl_rd_data | output | 32 | Table read data, combinational |
| evt_req | input | NUM_VEC | Per-vector event pulses |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Sender accepts the message |
| msg_vec | output | VEC_W | Vector number of the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| pend_bits | output | NUM_VEC | Pending bit of every vector |
| legacy_in | input | 1 | Legacy interrupt level in |
| legacy_out | output | 1 | Legacy interrupt level out |

## Verification
The embedded properties assume that every strobe lasts a single cycle and that cfg_wr_len never exceeds 4. They also assume that msg_ready may fall at any time but is changed only between clock edges. The directed tasks follow these rules, so every stall seen at the message port comes from the bench holding msg_ready low on purpose. The tasks make the sweep, the direct path and the table-write replay meet: events are raised while the function mask is set, a sweep is left stalled at a vector, and an event is then injected for a vector the sweep has already passed. The order of the logged messages is compared against the ascending order that the requirements demand.

// File: rtl/msgvec_pkg.sv
// Shared constants, sweep state type and config byte-range helper.
// Assumes configuration writes are at most four bytes long.
package msgvec_pkg;
    localparam int ENTRY_SHIFT = 4;
    localparam logic [1:0] W_ADDR_LO = 2'd0;
    localparam logic [1:0] W_ADDR_HI = 2'd1;
    localparam logic [1:0] W_DATA    = 2'd2;
    localparam logic [1:0] W_VCTRL   = 2'd3;

    typedef enum logic [1:0] {SW_IDLE, SW_SCAN, SW_WAIT} sweep_e;

    // True when byte address tgt lies in [a, a+len).
    function automatic logic byte_covered(input logic [7:0] a,
                                          input logic [2:0] len,
                                          input logic [7:0] tgt);
        logic [8:0] lo, hi, t;
        lo = {1'b0, a};
        hi = {1'b0, a} + {6'd0, len};
        t  = {1'b0, tgt};
        return (t >= lo) && (t < hi);
    endfunction
endpackage

// File: rtl/msgvec_cfg.sv
// Capability control word: decodes configuration writes that reach the
// control byte, keeps the enable and function-mask flags, and drives the
// legacy interrupt output. ctrl_hit pulses one cycle after a control-byte
// write, together with the updated flags.
module msgvec_cfg #(
    parameter int          NUM_VEC    = 8,
    parameter logic [7:0]  CAP_BASE   = 8'h40,
    parameter logic [2:0]  BAR_SEL    = 3'd2,
    parameter logic [31:0] TBL_OFFSET = 32'h0000_2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [7:0]  cfg_wr_addr,
    input  logic [2:0]  cfg_wr_len,
    input  logic [31:0] cfg_wr_data,
    input  logic        legacy_in,
    output logic        en,
    output logic        fmask,
    output logic        ctrl_hit,
    output logic [15:0] ctrl_word,
    output logic [31:0] tbl_word,
    output logic        legacy_out
);
    import msgvec_pkg::*;

    localparam logic [7:0]  CTRL_BYTE = CAP_BASE + 8'd3;
    localparam logic [10:0] QSIZE     = 11'(NUM_VEC - 1);

    logic       hit;
    logic [7:0] lane_diff;
    logic [7:0] ctrl_byte_val;
    logic       en_nx, fm_nx;
    logic       en_q, fm_q, hit_q, leg_q;

    // Decode whether this write reaches the control byte and pick its lane.
    always_comb begin
        hit           = cfg_wr_en && byte_covered(cfg_wr_addr, cfg_wr_len, CTRL_BYTE);
        lane_diff     = CTRL_BYTE - cfg_wr_addr;
        ctrl_byte_val = cfg_wr_data[{lane_diff[1:0], 3'b000} +: 8];
        en_nx         = hit ? ctrl_byte_val[7] : en_q;
        fm_nx         = hit ? ctrl_byte_val[6] : fm_q;
    end

    // Flag storage, write pulse and legacy output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            fm_q  <= 1'b0;
            hit_q <= 1'b0;
            leg_q <= 1'b0;
        end else begin
            en_q  <= en_nx;
            fm_q  <= fm_nx;
            hit_q <= hit;
            leg_q <= legacy_in & ~en_nx;
        end
    end

    assign en         = en_q;
    assign fmask      = fm_q;
    assign ctrl_hit   = hit_q;
    assign ctrl_word  = {en_q, fm_q, 3'b000, QSIZE};
    assign tbl_word   = {TBL_OFFSET[31:3], BAR_SEL};
    assign legacy_out = leg_q;

    // R11: legacy line is held low while vector mode is on.
    p_legacy_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> !leg_q);
endmodule

// File: rtl/msgvec_table.sv
// Per-vector message table: address low/high, data and mask bit.
// Write addresses are word aligned by dropping bits 1:0; the vector index
// is the address divided by the 16-byte entry size. Provides a read port,
// a second lookup port for the message sender and the post-write mask.
module msgvec_table #(
    parameter int NUM_VEC = 8,
    parameter int VEC_W   = $clog2(NUM_VEC),
    parameter int TBL_AW  = VEC_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [TBL_AW-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [TBL_AW-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    input  logic [VEC_W-1:0]   sel_idx,
    output logic [63:0]        sel_addr,
    output logic [31:0]        sel_data,
    output logic [NUM_VEC-1:0] vmask,
    output logic [VEC_W-1:0]   wr_vec,
    output logic               wr_mask_nx
);
    import msgvec_pkg::*;

    logic [31:0]        addr_lo [NUM_VEC];
    logic [31:0]        addr_hi [NUM_VEC];
    logic [31:0]        mdata   [NUM_VEC];
    logic [NUM_VEC-1:0] mask_q;
    logic [1:0]         wr_word;
    logic [VEC_W-1:0]   rd_vec;
    logic [1:0]         rd_word;

    assign wr_vec  = wr_addr[TBL_AW-1:ENTRY_SHIFT];
    assign wr_word = wr_addr[3:2];
    assign rd_vec  = rd_addr[TBL_AW-1:ENTRY_SHIFT];
    assign rd_word = rd_addr[3:2];

    // Mask value the written vector will hold after this write.
    assign wr_mask_nx = (wr_word == W_VCTRL) ? wr_data[0] : mask_q[wr_vec];

    // One storage slice per vector.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
        // Entry update on writes addressed to this vector.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_lo[g] <= '0;
                addr_hi[g] <= '0;
                mdata[g]   <= '0;
                mask_q[g]  <= 1'b1;
            end else if (wr_en && wr_vec == VEC_W'(g)) begin
                case (wr_word)
                    W_ADDR_LO: addr_lo[g] <= wr_data;
                    W_ADDR_HI: addr_hi[g] <= wr_data;
                    W_DATA:    mdata[g]   <= wr_data;
                    default:   mask_q[g]  <= wr_data[0];
                endcase
            end
        end
    end

    // Software read mux.
    always_comb begin
        case (rd_word)
            W_ADDR_LO: rd_data = addr_lo[rd_vec];
            W_ADDR_HI: rd_data = addr_hi[rd_vec];
            W_DATA:    rd_data = mdata[rd_vec];
            default:   rd_data = {31'd0, mask_q[rd_vec]};
        endcase
    end

    assign sel_addr = {addr_hi[sel_idx], addr_lo[sel_idx]};
    assign sel_data = mdata[sel_idx];
    assign vmask    = mask_q;
endmodule

// File: rtl/msgvec_sender.sv
// Message output stage: takes the lowest set bit of the send queue
// whenever the output register is free or being accepted, and holds the
// request stable until msg_ready. Assumes table fields for the picked
// vector are presented on sel_addr/sel_data in the same cycle.
module msgvec_sender #(
    parameter int NUM_VEC = 8,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] send_bits,
    output logic [NUM_VEC-1:0] take,
    output logic [VEC_W-1:0]   pick_idx,
    input  logic [63:0]        sel_addr,
    input  logic [31:0]        sel_data,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [VEC_W-1:0]   msg_vec,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    logic             found;
    logic             can_load;
    logic             v_q;
    logic [VEC_W-1:0] vec_q;
    logic [63:0]      addr_q;
    logic [31:0]      data_q;

    // Lowest-index pick among queued vectors.
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (!found && send_bits[i]) begin
                found    = 1'b1;
                pick_idx = VEC_W'(i);
            end
        end
        can_load = !v_q || msg_ready;
        take     = (can_load && found) ? (NUM_VEC'(1) << pick_idx) : '0;
    end

    // Output register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            vec_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (can_load) begin
            v_q <= found;
            if (found) begin
                vec_q  <= pick_idx;
                addr_q <= sel_addr;
                data_q <= sel_data;
            end
        end
    end

    assign msg_valid = v_q;
    assign msg_vec   = vec_q;
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;

    // R12: a stalled request keeps its contents.
    p_msg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && !msg_ready) |=> (v_q && $stable(vec_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/msgvec_ctrl.sv
// Top: pending and send queues plus the replay sweep. Events on masked
// vectors become pending; unmasked ones are queued to send. Table writes
// replay their own vector; a control-byte write that leaves vector mode on
// and the function unmasked sweeps all vectors, one replay at a time.
module msgvec_ctrl #(
    parameter int          NUM_VEC    = 8,
    parameter logic [7:0]  CAP_BASE   = 8'h40,
    parameter logic [2:0]  BAR_SEL    = 3'd2,
    parameter logic [31:0] TBL_OFFSET = 32'h0000_2000,
    parameter int          VEC_W      = $clog2(NUM_VEC),
    parameter int          TBL_AW     = VEC_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [7:0]         cfg_wr_addr,
    input  logic [2:0]         cfg_wr_len,
    input  logic [31:0]        cfg_wr_data,
    output logic [15:0]        cfg_ctrl_word,
    output logic [31:0]        cfg_tbl_word,
    input  logic               tbl_wr_en,
    input  logic [TBL_AW-1:0]  tbl_wr_addr,
    input  logic [31:0]        tbl_wr_data,
    input  logic [TBL_AW-1:0]  tbl_rd_addr,
    output logic [31:0]        tbl_rd_data,
    input  logic [NUM_VEC-1:0] evt_req,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [VEC_W-1:0]   msg_vec,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [NUM_VEC-1:0] pend_bits,
    input  logic               legacy_in,
    output logic               legacy_out
);
    import msgvec_pkg::*;

    localparam logic [VEC_W-1:0] LAST_VEC = VEC_W'(NUM_VEC - 1);

    logic               en, fmask, ctrl_hit;
    logic [NUM_VEC-1:0] vmask, masked;
    logic [VEC_W-1:0]   wr_vec, pick_idx;
    logic               wr_mask_nx;
    logic [63:0]        sel_addr;
    logic [31:0]        sel_data;
    logic [NUM_VEC-1:0] take;
    logic [NUM_VEC-1:0] pend_q, pend_nx, send_q, send_nx;
    sweep_e             sw_q, sw_nx;
    logic [VEC_W-1:0]   idx_q, idx_nx;

    msgvec_cfg #(.NUM_VEC(NUM_VEC), .CAP_BASE(CAP_BASE), .BAR_SEL(BAR_SEL),
                 .TBL_OFFSET(TBL_OFFSET)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_len(cfg_wr_len), .cfg_wr_data(cfg_wr_data), .legacy_in(legacy_in),
        .en(en), .fmask(fmask), .ctrl_hit(ctrl_hit), .ctrl_word(cfg_ctrl_word),
        .tbl_word(cfg_tbl_word), .legacy_out(legacy_out));

    msgvec_table #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .TBL_AW(TBL_AW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
        .wr_data(tbl_wr_data), .rd_addr(tbl_rd_addr), .rd_data(tbl_rd_data),
        .sel_idx(pick_idx), .sel_addr(sel_addr), .sel_data(sel_data),
        .vmask(vmask), .wr_vec(wr_vec), .wr_mask_nx(wr_mask_nx));

    msgvec_sender #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_snd (
        .clk(clk), .rst_n(rst_n), .send_bits(send_q), .take(take), .pick_idx(pick_idx),
        .sel_addr(sel_addr), .sel_data(sel_data), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vec(msg_vec), .msg_addr(msg_addr), .msg_data(msg_data));

    assign masked = vmask | {NUM_VEC{fmask}};

    // Next pending/send queues and sweep position.
    always_comb begin
        pend_nx = pend_q;
        send_nx = send_q & ~take;
        sw_nx   = sw_q;
        idx_nx  = idx_q;
        if (en) begin
            pend_nx = pend_nx | (evt_req & masked);
            send_nx = send_nx | (evt_req & ~masked);
        end
        if (tbl_wr_en && en && !fmask && !wr_mask_nx && pend_nx[wr_vec]) begin
            pend_nx[wr_vec] = 1'b0;
            send_nx[wr_vec] = 1'b1;
        end
        if (ctrl_hit) begin
            sw_nx  = (en && !fmask) ? SW_SCAN : SW_IDLE;
            idx_nx = '0;
        end else begin
            case (sw_q)
                SW_SCAN: begin
                    if (pend_nx[idx_q] && !masked[idx_q]) begin
                        pend_nx[idx_q] = 1'b0;
                        send_nx[idx_q] = 1'b1;
                        sw_nx          = SW_WAIT;
                    end else if (idx_q == LAST_VEC) begin
                        sw_nx = SW_IDLE;
                    end else begin
                        idx_nx = idx_q + 1'b1;
                    end
                end
                SW_WAIT: begin
                    if (!send_q[idx_q] && !(msg_valid && msg_vec == idx_q)) begin
                        if (idx_q == LAST_VEC) begin
                            sw_nx = SW_IDLE;
                        end else begin
                            sw_nx  = SW_SCAN;
                            idx_nx = idx_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Queue and sweep registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            send_q <= '0;
            sw_q   <= SW_IDLE;
            idx_q  <= '0;
        end else begin
            pend_q <= pend_nx;
            send_q <= send_nx;
            sw_q   <= sw_nx;
            idx_q  <= idx_nx;
        end
    end

    assign pend_bits = pend_q;

    // R5: a masked event while enabled leaves its pending bit set.
    p_pend_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tbl_wr_en && sw_q == SW_IDLE && |(evt_req & masked))
        |=> ((pend_q & $past(evt_req & masked)) == $past(evt_req & masked)));

    // R7: no new pending bits appear while vector mode is off.
    p_no_pend_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((pend_q & ~$past(pend_q)) == '0));

    // R9: the sweep position only steps forward by one, or restarts.
    p_sweep_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q != SW_IDLE && !ctrl_hit && idx_q != LAST_VEC)
        |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1 || $past(ctrl_hit)));

    // R10: no sweep runs once the function is masked or mode is off.
    p_no_sweep_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((fmask || !en) && !ctrl_hit) |-> (sw_q == SW_IDLE));
endmodule

// File: tb/tb_msgvec_ctrl.sv
module tb_msgvec_ctrl;
    localparam int NV = 8;
    localparam int VW = 3;
    localparam int AW = 7;
    localparam logic [7:0] CB = 8'h43;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_addr = '0;
    logic [2:0] cfg_wr_len = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [15:0] cfg_ctrl_word;
    logic [31:0] cfg_tbl_word;
    logic tbl_wr_en = 1'b0;
    logic [AW-1:0] tbl_wr_addr = '0;
    logic [31:0] tbl_wr_data = '0;
    logic [AW-1:0] tbl_rd_addr = '0;
    logic [31:0] tbl_rd_data;
    logic [NV-1:0] evt_req = '0;
    logic msg_valid;
    logic msg_ready = 1'b1;
    logic [VW-1:0] msg_vec;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [NV-1:0] pend_bits;
    logic legacy_in = 1'b0;
    logic legacy_out;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int lcnt = 0;
    logic [VW-1:0] logv [32];
    logic [63:0]   loga [32];
    logic [31:0]   logd [32];

    always #2.5 clk = ~clk;

    msgvec_ctrl dut (.*);

    // Message monitor: records each accepted request just before the edge.
    always @(negedge clk) begin
        #2;
        if (msg_valid && msg_ready && lcnt < 32) begin
            logv[lcnt] = msg_vec;
            loga[lcnt] = msg_addr;
            logd[lcnt] = msg_data;
            lcnt = lcnt + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [2:0] len, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_len = len; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        idle(2);
    endtask

    task automatic tbl_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic tbl_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        tbl_rd_addr = a;
        #1 d = tbl_rd_data;
    endtask

    task automatic fire(input logic [NV-1:0] v);
        @(negedge clk);
        evt_req = v;
        @(negedge clk);
        evt_req = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check(cfg_ctrl_word == 16'h0007, "R1 reset ctrl word", 64'(cfg_ctrl_word), 64'h0007);
        check(cfg_tbl_word[2:0] == 3'd2, "R2 bar select", 64'(cfg_tbl_word[2:0]), 64'd2);
        check(cfg_tbl_word[31:3] == 29'h400, "R2 table offset", 64'(cfg_tbl_word[31:3]), 64'h400);
        tbl_read(7'h1C, d);
        check(d == 32'd1, "R4 reset mask set", 64'(d), 64'd1);
        check(pend_bits == '0 && !msg_valid, "R5 reset no pending", 64'(pend_bits), 64'd0);
    endtask

    task automatic t_table_layout;
        logic [31:0] d;
        tbl_write(7'h33, 32'h1234_5670);
        tbl_write(7'h34, 32'h0000_00AB);
        tbl_write(7'h3A, 32'hCAFE_0003);
        tbl_write(7'h3C, 32'hFFFF_FFFE);
        tbl_read(7'h30, d);
        check(d == 32'h1234_5670, "R4 aligned address low", 64'(d), 64'h12345670);
        tbl_read(7'h38, d);
        check(d == 32'hCAFE_0003, "R4 data word", 64'(d), 64'hCAFE0003);
        tbl_read(7'h3C, d);
        check(d == 32'd0, "R4 vector control bit 0 only", 64'(d), 64'd0);
    endtask

    task automatic t_disabled_drop;
        lcnt = 0;
        legacy_in = 1'b1;
        fire(8'h08);
        idle(6);
        check(pend_bits == '0 && lcnt == 0, "R7 event dropped while disabled", 64'(lcnt), 64'd0);
        check(legacy_out == 1'b1, "R11 legacy follows input", 64'(legacy_out), 64'd1);
    endtask

    task automatic t_ignore_cfg;
        cfg_write(8'h40, 3'd3, 32'hFFFF_FFFF);
        cfg_write(8'h44, 3'd4, 32'hFFFF_FFFF);
        check(cfg_ctrl_word == 16'h0007, "R3 write missing control byte ignored", 64'(cfg_ctrl_word), 64'h0007);
        cfg_write(8'h40, 3'd4, 32'h8000_0000);
        check(cfg_ctrl_word == 16'h8007, "R1 enable via 4-byte write", 64'(cfg_ctrl_word), 64'h8007);
        check(legacy_out == 1'b0, "R11 legacy low when enabled", 64'(legacy_out), 64'd0);
    endtask

    task automatic t_direct;
        lcnt = 0;
        fire(8'h08);
        idle(6);
        check(lcnt == 1 && logv[0] == 3'd3, "R6 direct message vector", 64'(logv[0]), 64'd3);
        check(loga[0] == 64'h0000_00AB_1234_5670, "R6 message address", loga[0], 64'h000000AB12345670);
        check(logd[0] == 32'hCAFE_0003, "R6 message data", 64'(logd[0]), 64'hCAFE0003);
    endtask

    task automatic t_masked_then_table;
        lcnt = 0;
        fire(8'h02);
        idle(6);
        check(pend_bits == 8'h02 && lcnt == 0, "R5 masked vector goes pending", 64'(pend_bits), 64'h02);
        tbl_write(7'h1C, 32'h0);
        idle(6);
        check(lcnt == 1 && logv[0] == 3'd1 && pend_bits == '0, "R8 table write replays", 64'(logv[0]), 64'd1);
    endtask

    task automatic t_sweep;
        lcnt = 0;
        cfg_write(CB, 3'd1, 32'h0000_00C0);
        fire(8'h4A);
        idle(4);
        tbl_write(7'h6C, 32'h0);
        idle(6);
        check(pend_bits == 8'h4A && lcnt == 0, "R8 no replay under function mask", 64'(pend_bits), 64'h4A);
        cfg_write(CB, 3'd1, 32'h0000_00C0);
        idle(8);
        check(lcnt == 0 && pend_bits == 8'h4A, "R10 masked control write no replay", 64'(lcnt), 64'd0);
        cfg_write(CB, 3'd1, 32'h0000_0080);
        idle(30);
        check(lcnt == 3 && logv[0] == 3'd1 && logv[1] == 3'd3 && logv[2] == 3'd6,
              "R9 sweep ascending order", {logv[0], logv[1], logv[2]}, {3'd1, 3'd3, 3'd6});
        check(pend_bits == '0, "R9 sweep clears pending", 64'(pend_bits), 64'd0);
    endtask

    task automatic t_sweep_stall;
        bit stable_ok;
        lcnt = 0;
        msg_ready = 1'b0;
        cfg_write(CB, 3'd1, 32'h0000_00C0);
        tbl_write(7'h2C, 32'h0);
        tbl_write(7'h0C, 32'h0);
        fire(8'h04);
        idle(3);
        cfg_write(CB, 3'd1, 32'h0000_0080);
        idle(8);
        fire(8'h01);
        stable_ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!msg_valid || msg_vec != 3'd2) stable_ok = 1'b0;
        end
        check(stable_ok, "R12 stalled request held", 64'(msg_vec), 64'd2);
        msg_ready = 1'b1;
        idle(12);
        check(lcnt == 2 && logv[0] == 3'd2 && logv[1] == 3'd0,
              "R13 passed vector delivered during sweep", {logv[0], logv[1]}, {3'd2, 3'd0});
    endtask

    task automatic t_disable_keep;
        lcnt = 0;
        cfg_write(CB, 3'd1, 32'h0000_00C0);
        fire(8'h04);
        idle(3);
        cfg_write(CB, 3'd1, 32'h0000_0000);
        idle(8);
        check(lcnt == 0 && pend_bits == 8'h04, "R10 disable write keeps pending", 64'(pend_bits), 64'h04);
        check(legacy_out == 1'b1, "R11 legacy back after disable", 64'(legacy_out), 64'd1);
        fire(8'h20);
        idle(4);
        check(pend_bits == 8'h04 && lcnt == 0, "R7 event dropped after disable", 64'(pend_bits), 64'h04);
    endtask

    task automatic t_priority;
        lcnt = 0;
        cfg_write(CB, 3'd1, 32'h0000_0080);
        idle(20);
        check(lcnt == 1 && logv[0] == 3'd2, "R9 re-enable replays pending", 64'(logv[0]), 64'd2);
        lcnt = 0;
        fire(8'h09);
        idle(8);
        check(lcnt == 2 && logv[0] == 3'd0 && logv[1] == 3'd3,
              "R6 lowest vector first", {logv[0], logv[1]}, {3'd0, 3'd3});
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_table_layout();
        t_disabled_drop();
        t_ignore_cfg();
        t_direct();
        t_masked_then_table();
        t_sweep();
        t_sweep_stall();
        t_disable_keep();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule